// File: doc/BRIEF.md
# Negative-Delta-V Charge Termination Detector

This block judges the cell-voltage readings that a charge sequencer gathers during the short test windows of a nickel-cell fast charge. Each test window arrives as a one-cycle strobe. The strobe carries two readings. One is taken with the charge current switched off (the rested reading). The other is taken while current flows (the loaded reading). From these the block decides one of four things: the charge has finished on a voltage drop, the voltage has gone flat for too long, the cell impedance is too high, or a reading exceeds the open-circuit ceiling.

The block keeps the highest rested reading seen since fast charge began. It also runs two minute counters driven by an external one-minute tick. The first is a hold-off counter that masks drop and flat decisions early in the charge. The second is a no-new-peak counter for the flat decision. A start pulse clears the peak and both counters.

Voltages are unsigned codes at 1 mV per step in a 12-bit field. The impedance threshold and the voltage ceiling are codes of the same scale. The sequencer sends a strobe about every 31 seconds and reacts to the single-cycle verdict pulses.

Top module: `ndv_term_detect`

## Requirements
- R1: While reset is high and in the first cycle after it, all four verdict outputs are low and the retained peak is zero.
- R2: The retained peak is the highest rested reading strobed since the last start pulse. A strobe whose rested reading is strictly above the peak replaces the peak.
- R3: Drop termination: once hold-off has ended, a strobe whose rested reading is more than 2 codes below the retained peak raises `done_o`. A reading exactly 2 codes below does not.
- R4: Flat termination: once hold-off has ended, a strobe with no new peak raises `flat_o` if 16 or more minute ticks have passed since the last start pulse or new peak. After 15 ticks it does not.
- R5: Hold-off: drop and flat verdicts are suppressed until 4 minute ticks have passed since the start pulse.
- R6: Impedance: a strobe whose loaded reading exceeds its rested reading by more than `imp_thr_i` raises `imp_fail_o`. A difference equal to the threshold does not.
- R7: Overvoltage: a strobe whose rested or loaded reading is above `v_limit_i` raises `ov_fail_o`.
- R8: At most one verdict per strobe, chosen in the order overvoltage, impedance, drop, flat.
- R9: A verdict is high for exactly the one cycle that follows its strobe. Without a strobe, all verdicts stay low.
- R10: A start pulse clears the peak, the hold-off counter and the flat counter. A strobe in the same cycle as a start pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_start_i | input | 1 | Start-of-fast-charge pulse |
| test_stb_i | input | 1 | One-cycle strobe: readings are valid |
| v_rest_i | input | 12 | Rested cell voltage code |
| v_load_i | input | 12 | Loaded cell voltage code |
| imp_thr_i | input | 12 | Impedance difference threshold code |
| v_limit_i | input | 12 | Open-circuit voltage ceiling code |
| min_tick_i | input | 1 | One-cycle pulse each minute |
| done_o | output | 1 | Drop termination verdict |
| flat_o | output | 1 | Flat-voltage timeout verdict |
| imp_fail_o | output | 1 | Impedance failure verdict |
| ov_fail_o | output | 1 | Overvoltage failure verdict |

## Verification
A single strobe can satisfy the impedance test and the drop test together. A loaded reading well above a rested reading that has sagged below the peak does both. The stimulus table includes such a vector after hold-off has ended. The bench expects only `imp_fail_o`, with `done_o` low in that cycle. Another vector exceeds the ceiling and the impedance threshold at once, and only `ov_fail_o` may rise.

// File: rtl/ndv_pkg.sv
package ndv_pkg;
  typedef enum logic [2:0] {
    VERD_NONE = 3'd0,
    VERD_OV   = 3'd1,
    VERD_IMP  = 3'd2,
    VERD_DROP = 3'd3,
    VERD_FLAT = 3'd4
  } verdict_e;
endpackage

// File: rtl/ndv_min_timer.sv
module ndv_min_timer #(
  parameter int LIMIT = 16,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  output logic reached_o
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt <= '0;
    else if (tick_i && cnt != LIM)
      cnt <= cnt + 1'b1;
  end

  assign reached_o = (cnt == LIM);

  // R4/R5: counter saturates at its limit
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
  // R10: clear brings the count back to zero
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt == '0);
endmodule

// File: rtl/ndv_peak_track.sv
module ndv_peak_track #(
  parameter int VW   = 12,
  parameter int DROP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          sample_i,
  input  logic [VW-1:0] v_rest_i,
  output logic          new_peak_o,
  output logic          drop_o
);
  logic [VW-1:0] peak;
  logic [VW:0]   floor_ext;

  assign new_peak_o = v_rest_i > peak;
  assign floor_ext  = {1'b0, v_rest_i} + (VW+1)'(DROP);
  assign drop_o     = {1'b0, peak} > floor_ext;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      peak <= '0;
    else if (sample_i && new_peak_o)
      peak <= v_rest_i;
  end

  // R2: peak never decreases except on clear
  p_peak_mono_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_i) |-> peak >= $past(peak));
  // R10: clear zeroes the peak
  p_peak_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> peak == '0);
endmodule

// File: rtl/ndv_verdict.sv
module ndv_verdict
  import ndv_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic [VW-1:0] v_rest_i,
  input  logic [VW-1:0] v_load_i,
  input  logic [VW-1:0] imp_thr_i,
  input  logic [VW-1:0] v_limit_i,
  input  logic          hold_ok_i,
  input  logic          drop_i,
  input  logic          flat_exp_i,
  input  logic          new_peak_i,
  output verdict_e      verdict_o
);
  logic [VW:0] diff;
  logic        ov, imp, drp, flt;

  assign diff = {1'b0, v_load_i} - {1'b0, v_rest_i};
  assign ov   = (v_rest_i > v_limit_i) || (v_load_i > v_limit_i);
  assign imp  = (v_load_i > v_rest_i) && (diff[VW-1:0] > imp_thr_i);
  assign drp  = hold_ok_i && drop_i;
  assign flt  = hold_ok_i && flat_exp_i && !new_peak_i;

  always_comb begin
    if (ov)       verdict_o = VERD_OV;
    else if (imp) verdict_o = VERD_IMP;
    else if (drp) verdict_o = VERD_DROP;
    else if (flt) verdict_o = VERD_FLAT;
    else          verdict_o = VERD_NONE;
  end
endmodule

// File: rtl/ndv_term_detect.sv
module ndv_term_detect
  import ndv_pkg::*;
#(
  parameter int VW       = 12,
  parameter int DROP     = 2,
  parameter int HOLD_MIN = 4,
  parameter int FLAT_MIN = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fc_start_i,
  input  logic          test_stb_i,
  input  logic [VW-1:0] v_rest_i,
  input  logic [VW-1:0] v_load_i,
  input  logic [VW-1:0] imp_thr_i,
  input  logic [VW-1:0] v_limit_i,
  input  logic          min_tick_i,
  output logic          done_o,
  output logic          flat_o,
  output logic          imp_fail_o,
  output logic          ov_fail_o
);
  logic     sample, new_peak, drop, hold_ok, flat_exp;
  verdict_e verdict;

  assign sample = test_stb_i && !fc_start_i;

  ndv_peak_track #(.VW(VW), .DROP(DROP)) u_peak (
    .clk(clk), .rst(rst), .clr_i(fc_start_i), .sample_i(sample),
    .v_rest_i(v_rest_i), .new_peak_o(new_peak), .drop_o(drop));

  ndv_min_timer #(.LIMIT(HOLD_MIN)) u_hold (
    .clk(clk), .rst(rst), .clr_i(fc_start_i), .tick_i(min_tick_i),
    .reached_o(hold_ok));

  ndv_min_timer #(.LIMIT(FLAT_MIN)) u_flat (
    .clk(clk), .rst(rst), .clr_i(fc_start_i || (sample && new_peak)),
    .tick_i(min_tick_i), .reached_o(flat_exp));

  ndv_verdict #(.VW(VW)) u_verd (
    .v_rest_i(v_rest_i), .v_load_i(v_load_i), .imp_thr_i(imp_thr_i),
    .v_limit_i(v_limit_i), .hold_ok_i(hold_ok), .drop_i(drop),
    .flat_exp_i(flat_exp), .new_peak_i(new_peak), .verdict_o(verdict));

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      flat_o     <= 1'b0;
      imp_fail_o <= 1'b0;
      ov_fail_o  <= 1'b0;
    end else begin
      ov_fail_o  <= sample && verdict == VERD_OV;
      imp_fail_o <= sample && verdict == VERD_IMP;
      done_o     <= sample && verdict == VERD_DROP;
      flat_o     <= sample && verdict == VERD_FLAT;
    end
  end

  // R8: never more than one verdict at a time
  p_one_verdict_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, flat_o, imp_fail_o, ov_fail_o}));
  // R9: verdicts only follow an accepted strobe
  p_after_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o || flat_o || imp_fail_o || ov_fail_o)
      |-> ($past(test_stb_i) && !$past(fc_start_i)));
  // R5: drop and flat only once hold-off has ended
  p_holdoff_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o || flat_o) |-> $past(hold_ok));
endmodule

// File: tb/sim_ndv_term_detect.sv
module sim_ndv_term_detect;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // fields: ticks[35:28] rest[27:16] load[15:4] expected {ov,imp,done,flat}[3:0]
  localparam logic [35:0] VEC [0:NV-1] = '{
    {8'd0,  12'd1200, 12'd1230, 4'b0000},  // R2 first peak, hold-off active
    {8'd1,  12'd1190, 12'd1220, 4'b0000},  // R5 drop masked by hold-off
    {8'd3,  12'd1198, 12'd1220, 4'b0000},  // R3 exactly 2 below: no verdict
    {8'd0,  12'd1197, 12'd1230, 4'b0010},  // R3 3 below: done
    {8'd0,  12'd1205, 12'd1240, 4'b0000},  // R2 new peak
    {8'd0,  12'd1100, 12'd1200, 4'b0100},  // R8 imp and drop: imp wins
    {8'd0,  12'd1205, 12'd1700, 4'b1000},  // R7 load over ceiling, beats imp
    {8'd0,  12'd1205, 12'd1255, 4'b0000},  // R6 difference equal: no fail
    {8'd16, 12'd1205, 12'd1210, 4'b0001},  // R4 16 ticks, no new peak: flat
    {8'd0,  12'd1660, 12'd1670, 4'b1000}   // R7 rest over ceiling
  };

  logic clk = 1'b0, rst = 1'b1;
  logic fc_start = 1'b0, stb = 1'b0, tick = 1'b0;
  logic [11:0] v_rest = '0, v_load = '0, thr = 12'd50, lim = 12'd1650;
  logic done, flat, impf, ovf;
  int errors = 0, checks = 0, cycles = 0;

  ndv_term_detect u0 (
    .clk(clk), .rst(rst), .fc_start_i(fc_start), .test_stb_i(stb),
    .v_rest_i(v_rest), .v_load_i(v_load), .imp_thr_i(thr),
    .v_limit_i(lim), .min_tick_i(tick), .done_o(done), .flat_o(flat),
    .imp_fail_o(impf), .ov_fail_o(ovf));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input logic [3:0] exp, input string req);
    checks++;
    if ({ovf, impf, done, flat} !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req,
               {ovf, impf, done, flat}, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic start_pulse();
    @(negedge clk) fc_start = 1'b1;
    @(negedge clk) fc_start = 1'b0;
  endtask

  task automatic strobe(input logic [11:0] r, input logic [11:0] l,
                        input logic [3:0] exp, input string req);
    @(negedge clk);
    stb = 1'b1; v_rest = r; v_load = l;
    @(negedge clk);
    stb = 1'b0;
    check(exp, req);
    @(negedge clk);
    check(4'b0000, "R9 single-cycle pulse");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(4'b0000, "R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check(4'b0000, "R1 after reset");

    start_pulse();
    for (int k = 0; k < NV; k++) begin
      ticks(int'(VEC[k][35:28]));
      strobe(VEC[k][27:16], VEC[k][15:4], VEC[k][3:0], $sformatf("vector %0d", k));
    end

    // R10: strobe with start is ignored and start clears the peak (was 1660)
    @(negedge clk);
    fc_start = 1'b1; stb = 1'b1; v_rest = 12'd1300; v_load = 12'd1310;
    @(negedge clk);
    fc_start = 1'b0; stb = 1'b0;
    check(4'b0000, "R10 strobe with start");
    ticks(4);
    strobe(12'd1200, 12'd1210, 4'b0000, "R10 peak cleared by start");

    // R5 hold-off boundary, then R3 drop
    start_pulse();
    ticks(3);
    strobe(12'd1200, 12'd1210, 4'b0000, "R2 peak set");
    strobe(12'd1190, 12'd1200, 4'b0000, "R5 3 ticks still masked");
    ticks(1);
    strobe(12'd1190, 12'd1200, 4'b0010, "R3 drop after hold-off");

    // R4 flat boundary
    start_pulse();
    ticks(4);
    strobe(12'd1200, 12'd1210, 4'b0000, "R4 peak restarts flat timer");
    ticks(15);
    strobe(12'd1200, 12'd1210, 4'b0000, "R4 15 ticks: no flat");
    ticks(1);
    strobe(12'd1200, 12'd1210, 4'b0001, "R4 16 ticks: flat");

    // R9 no strobe, no verdict
    ticks(2);
    check(4'b0000, "R9 idle without strobe");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule